// File: doc/BRIEF.md
# Four-Source Vectored Interrupt Controller with Poll-and-Clear

This block sits beside a small microcontroller core. It gathers four interrupt sources: a level change on an external pin, two timer underflow pulses and an A/D conversion-done pulse. Each source owns a sticky pending flag and an enable bit. One global enable gate is opened by an enable-interrupts strobe and closed by a disable-interrupts strobe. When a source is pending, enabled and globally allowed, the controller raises a request to the core. It presents a 7-bit vector made of a page number and an offset, and waits for the core to acknowledge. The acknowledge clears both the serviced flag and the global gate.

The enable bit of a source picks how that source is used. When the bit is 1, the source interrupts. When the bit is 0, the source can only be polled. The core issues a poll-and-clear query naming one source. The controller answers "skip" if that flag is pending and its enable bit is 0, and then clears the flag.

The sequencer has two states. In `ST_IDLE` no request is shown. In `ST_REQ` a chosen source is latched and offered to the core. The transitions are:
- `T_RAISE` (`ST_IDLE` to `ST_REQ`): taken when any source qualifies.
- `T_ACK` (`ST_REQ` to `ST_IDLE`): taken when the core acknowledges a live request.
- `T_WITHDRAW` (`ST_REQ` to `ST_IDLE`): taken when the latched source stops qualifying.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A source's pending flag is set by its trigger event regardless of its enable bit and of the global gate. It then stays set until a clear condition occurs. A timer or A/D pulse sets the flag at the next clock edge.
- R2: `int_req` is 1 only while the offered source has its flag at 1, its enable bit at 1, and the global gate at 1.
- R3: When several sources qualify, the one chosen at `T_RAISE` follows a fixed priority. The external pin has the highest priority, then timer 1, then timer 2, with A/D lowest. `int_req` rises one cycle after the first edge at which a source qualifies.
- R4: `int_vec` is `{3'b001, offset}` while `int_req` is 1, and 0 otherwise. The offset is 0x0 for the external pin, 0x4 for timer 1, 0x6 for timer 2 and 0xC for A/D. This gives vectors 0x10, 0x14, 0x16 and 0x1C.
- R5: An `int_ack` while `int_req` is 1 clears the offered source's flag and the global gate at the same edge. `int_req` is 0 in the following cycle.
- R6: `gie_set` sets the global gate and `gie_clr` clears it. When both are pulsed together, or `gie_set` coincides with a taken acknowledge, the gate ends at 0.
- R7: `skip_hit` equals `skip_qry` AND flag[`skip_sel`] AND NOT enable[`skip_sel`]. A hit clears that flag at the next edge. With the enable bit at 1 the query has no effect on the flag. `skip_sel` and `en_wdata` use the index order 0 = external, 1 = timer 1, 2 = timer 2, 3 = A/D.
- R8: When a set event and a clear (skip hit or acknowledge) hit the same flag at the same edge, the flag ends at 1.
- R9: The external pin passes through a two-stage synchronizer. Both rising and falling edges set its flag, at the third clock edge after the pin changes.
- R10: After reset all flags, enable bits and the global gate are 0. `int_req`, `int_vec` and `skip_hit` are 0.
- R11: While `int_req` stays 1 without an acknowledge, `int_vec` does not change, even if a higher-priority source becomes pending. If the offered source stops qualifying, `int_req` drops at once.
- R12: A flag left pending while interrupts were gated raises a request as soon as the gate opens. `int_req` rises two edges after the `gie_set` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin, either edge triggers |
| tmr1_evt | input | 1 | One-cycle timer 1 underflow pulse |
| tmr2_evt | input | 1 | One-cycle timer 2 underflow pulse |
| adc_evt | input | 1 | One-cycle conversion-done pulse |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 4 | Enable bit values, index order as in R7 |
| gie_set | input | 1 | Enable-interrupts strobe |
| gie_clr | input | 1 | Disable-interrupts strobe |
| skip_qry | input | 1 | Poll-and-clear query strobe |
| skip_sel | input | 2 | Source polled by the query |
| skip_hit | output | 1 | Query answer: skip the next instruction |
| int_ack | input | 1 | Core accepts the offered interrupt |
| int_req | output | 1 | Interrupt request to the core |
| int_vec | output | 7 | Vector: page in bits 6:4, offset in bits 3:0 |

## Verification
A table of patterns applies different mixes of the four trigger events under different enable masks, with the global gate either open or shut. The single-source rows check each vector offset on its own. The mixed rows tell the priority order apart from the enable masking. The all-disabled and gate-shut rows separate "flag pending" from "request raised". Directed sequences then cover the following cases:
- acknowledge followed by re-enable, which shows the next-lower source;
- polls with the enable bit at 0 and at 1;
- a set that collides with a poll clear;
- simultaneous enable and disable strobes;
- withdrawal of a live request;
- a falling pin edge with exact cycle timing.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC   = 4;
    localparam int IDXW   = $clog2(NSRC);
    localparam int PAGE_W = 3;
    localparam int OFF_W  = 4;
    localparam int VEC_W  = PAGE_W + OFF_W;
    localparam logic [PAGE_W-1:0] VEC_PAGE = 3'd1;

    typedef enum logic [IDXW-1:0] {
        SRC_EXT0 = 2'd0,
        SRC_TMR1 = 2'd1,
        SRC_TMR2 = 2'd2,
        SRC_ADC  = 2'd3
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } vic_state_e;

    function automatic logic [OFF_W-1:0] src_offset(input logic [IDXW-1:0] idx);
        logic [OFF_W-1:0] off;
        unique case (idx)
            SRC_EXT0: off = 4'h0;
            SRC_TMR1: off = 4'h4;
            SRC_TMR2: off = 4'h6;
            default:  off = 4'hC;
        endcase
        return off;
    endfunction
endpackage

// File: rtl/vic_edge_sync.sv
module vic_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_pulse
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin};
    end

    assign edge_pulse = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/vic_flag_bank.sv
module vic_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (set_vec[i]) flag_q[i] <= 1'b1;
            else if (clr_vec[i]) flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/vic_prio_sel.sv
module vic_prio_sel #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] qual,
    output logic         any_qual,
    output logic [W-1:0] win_idx
);
    always_comb begin
        any_qual = 1'b0;
        win_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (qual[i]) begin
                any_qual = 1'b1;
                win_idx  = W'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             tmr1_evt,
    input  logic             tmr2_evt,
    input  logic             adc_evt,
    input  logic             en_wr,
    input  logic [NSRC-1:0]  en_wdata,
    input  logic             gie_set,
    input  logic             gie_clr,
    input  logic             skip_qry,
    input  logic [IDXW-1:0]  skip_sel,
    output logic             skip_hit,
    input  logic             int_ack,
    output logic             int_req,
    output logic [VEC_W-1:0] int_vec
);
    vic_state_e      state_q, state_d;
    logic [IDXW-1:0] chosen_q;
    logic [NSRC-1:0] en_q, flag_q, set_vec, clr_vec, qual;
    logic [NSRC-1:0] skip_oh, chosen_oh;
    logic            gie_q, ext_edge, any_qual, chosen_ok, take;
    logic [IDXW-1:0] win_idx;

    vic_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .edge_pulse(ext_edge)
    );

    assign set_vec = {adc_evt, tmr2_evt, tmr1_evt, ext_edge};

    // poll-and-clear path
    assign skip_oh  = NSRC'(1) << skip_sel;
    assign skip_hit = skip_qry & flag_q[skip_sel] & ~en_q[skip_sel];

    // acknowledge path
    assign chosen_oh = NSRC'(1) << chosen_q;
    assign qual      = flag_q & en_q & {NSRC{gie_q}};
    assign chosen_ok = qual[chosen_q];
    assign take      = int_req & int_ack;

    assign clr_vec = (skip_hit ? skip_oh : '0) | (take ? chosen_oh : '0);

    vic_flag_bank #(.N(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flag_q(flag_q)
    );

    vic_prio_sel #(.N(NSRC)) u_prio (
        .qual(qual), .any_qual(any_qual), .win_idx(win_idx)
    );

    // enable bits and global gate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else begin
            if (en_wr) en_q <= en_wdata;
            if (take || gie_clr) gie_q <= 1'b0;
            else if (gie_set)    gie_q <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            chosen_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && any_qual) chosen_q <= win_idx;
        end
    end

    // next state: T_RAISE, T_ACK, T_WITHDRAW
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_qual)   state_d = ST_REQ;
            ST_REQ:  if (take)       state_d = ST_IDLE;
                     else if (!chosen_ok) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        int_req = 1'b0;
        int_vec = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ: begin
                int_req = chosen_ok;
                if (chosen_ok) int_vec = {VEC_PAGE, src_offset(chosen_q)};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vic_checker.sv
module vic_checker
    import vic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  flag_q,
    input logic [NSRC-1:0]  en_q,
    input logic [NSRC-1:0]  set_vec,
    input logic             gie_q,
    input logic             gie_set,
    input logic             gie_clr,
    input logic             skip_qry,
    input logic             skip_hit,
    input logic             int_req,
    input logic             int_ack,
    input logic [VEC_W-1:0] int_vec
);
    p_req_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (gie_q && |(flag_q & en_q)));

    p_vec_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_vec[VEC_W-1:OFF_W] == VEC_PAGE));

    p_idle_vec_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req |-> (int_vec == '0));

    p_ack_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack) |=> (!gie_q && !int_req));

    p_gie_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_set && !gie_clr && !(int_req && int_ack)) |=> gie_q);

    p_gie_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |=> !gie_q);

    p_skip_needs_query_r7: assert property (@(posedge clk) disable iff (!rst_n)
        skip_hit |-> skip_qry);

    p_vec_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack) |=> (!int_req || $stable(int_vec)));

    for (genvar i = 0; i < NSRC; i++) begin : g_flag_chk
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]);
        p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q[i]) |-> $past(int_ack || skip_qry));
    end
endmodule

bind vec_irq_ctrl vic_checker u_vic_chk (
    .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .en_q(en_q), .set_vec(set_vec),
    .gie_q(gie_q), .gie_set(gie_set), .gie_clr(gie_clr), .skip_qry(skip_qry),
    .skip_hit(skip_hit), .int_req(int_req), .int_ack(int_ack), .int_vec(int_vec)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0, tmr1_evt = 1'b0, tmr2_evt = 1'b0, adc_evt = 1'b0;
    logic       en_wr = 1'b0, gie_set = 1'b0, gie_clr = 1'b0, skip_qry = 1'b0, int_ack = 1'b0;
    logic [3:0] en_wdata = 4'h0;
    logic [1:0] skip_sel = 2'd0;
    logic       skip_hit, int_req;
    logic [6:0] int_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr1_evt(tmr1_evt),
        .tmr2_evt(tmr2_evt), .adc_evt(adc_evt), .en_wr(en_wr), .en_wdata(en_wdata),
        .gie_set(gie_set), .gie_clr(gie_clr), .skip_qry(skip_qry), .skip_sel(skip_sel),
        .skip_hit(skip_hit), .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec)
    );

    // fields: ev[16:13] (bit0 ext), en[12:9], gie[8], exp_req[7], exp_vec[6:0]
    localparam logic [16:0] VEC_TBL [10] = '{
        {4'b0010, 4'b1111, 1'b1, 1'b1, 7'h14},
        {4'b1111, 4'b1111, 1'b1, 1'b1, 7'h10},
        {4'b1100, 4'b1111, 1'b1, 1'b1, 7'h16},
        {4'b1000, 4'b1000, 1'b1, 1'b1, 7'h1C},
        {4'b1111, 4'b0000, 1'b1, 1'b0, 7'h00},
        {4'b1111, 4'b1111, 1'b0, 1'b0, 7'h00},
        {4'b0111, 4'b1110, 1'b1, 1'b1, 7'h14},
        {4'b1110, 4'b1001, 1'b1, 1'b1, 7'h1C},
        {4'b0000, 4'b1111, 1'b1, 1'b0, 7'h00},
        {4'b0001, 4'b0001, 1'b1, 1'b1, 7'h10}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        ext_pin = 1'b0;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic write_en(input logic [3:0] v);
        en_wdata = v; en_wr = 1'b1; tick(); en_wr = 1'b0;
    endtask

    task automatic pulse_ei();
        gie_set = 1'b1; tick(); gie_set = 1'b0;
    endtask

    task automatic poll(input logic [1:0] sel, output logic hit);
        skip_sel = sel; skip_qry = 1'b1; #1; hit = skip_hit;
        tick(); skip_qry = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1; tick(); int_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic h;
        @(negedge clk);
        // R10: state held in reset
        chk("R10 req in reset", {6'd0, int_req}, 7'd0);
        do_reset();
        chk("R10 req", {6'd0, int_req}, 7'd0);
        chk("R10 vec", int_vec, 7'd0);
        for (int s = 0; s < 4; s++) begin
            poll(2'(s), h);
            chk("R10 skip", {6'd0, h}, 7'd0);
        end

        // table walk: R1, R2, R3, R4, R12
        for (int r = 0; r < 10; r++) begin
            logic [16:0] row;
            row = VEC_TBL[r];
            do_reset();
            write_en(row[12:9]);
            if (row[13]) begin
                ext_pin = ~ext_pin;
                repeat (4) tick();
            end
            tmr1_evt = row[14]; tmr2_evt = row[15]; adc_evt = row[16];
            tick();
            tmr1_evt = 1'b0; tmr2_evt = 1'b0; adc_evt = 1'b0;
            tick();
            chk("R1 held while gated", {6'd0, int_req}, 7'd0);
            if (row[8]) pulse_ei();
            tick(); tick();
            chk("R2/R12 req", {6'd0, int_req}, {6'd0, row[7]});
            chk("R3/R4 vec", int_vec, row[6:0]);
        end

        // R5: ack clears flag and gate; next source shows after EI
        do_reset();
        write_en(4'b1111);
        tmr1_evt = 1'b1; tmr2_evt = 1'b1; tick(); tmr1_evt = 1'b0; tmr2_evt = 1'b0;
        pulse_ei(); tick();
        chk("R5 first vec", int_vec, 7'h14);
        ack();
        chk("R5 req dropped", {6'd0, int_req}, 7'd0);
        tick();
        chk("R5 gate closed", {6'd0, int_req}, 7'd0);
        pulse_ei(); tick();
        chk("R5 t1 flag cleared", int_vec, 7'h16);
        ack();
        pulse_ei(); tick();
        chk("R5 all serviced", {6'd0, int_req}, 7'd0);

        // R7: polling with enable 0, then enable 1
        do_reset();
        write_en(4'b0100);
        adc_evt = 1'b1; tick(); adc_evt = 1'b0;
        poll(2'd3, h);
        chk("R7 poll hit", {6'd0, h}, 7'd1);
        poll(2'd3, h);
        chk("R7 flag cleared by poll", {6'd0, h}, 7'd0);
        tmr2_evt = 1'b1; tick(); tmr2_evt = 1'b0;
        poll(2'd2, h);
        chk("R7 enabled source not skipped", {6'd0, h}, 7'd0);
        pulse_ei(); tick();
        chk("R7 flag kept after poll", int_vec, 7'h16);

        // R8: set and poll clear collide
        do_reset();
        tmr1_evt = 1'b1; tick(); tmr1_evt = 1'b0;
        tmr1_evt = 1'b1; poll(2'd1, h); tmr1_evt = 1'b0;
        chk("R8 poll answered", {6'd0, h}, 7'd1);
        poll(2'd1, h);
        chk("R8 set wins", {6'd0, h}, 7'd1);

        // R6: EI and DI together leave gate shut
        do_reset();
        write_en(4'b0010);
        tmr1_evt = 1'b1; tick(); tmr1_evt = 1'b0;
        gie_set = 1'b1; gie_clr = 1'b1; tick(); gie_set = 1'b0; gie_clr = 1'b0;
        tick(); tick();
        chk("R6 both strobes", {6'd0, int_req}, 7'd0);

        // R11: vector held; withdraw on DI
        do_reset();
        write_en(4'b1111);
        tmr2_evt = 1'b1; tick(); tmr2_evt = 1'b0;
        pulse_ei(); tick();
        chk("R11 initial vec", int_vec, 7'h16);
        tmr1_evt = 1'b1; tick(); tmr1_evt = 1'b0;
        tick();
        chk("R11 vec held", int_vec, 7'h16);
        gie_clr = 1'b1; tick(); gie_clr = 1'b0;
        chk("R11 withdraw", {6'd0, int_req}, 7'd0);

        // R9: falling pin edge, exact timing
        ext_pin = 1'b1;
        do_reset();
        write_en(4'b0001);
        pulse_ei();
        ext_pin = 1'b1; repeat (4) tick();
        chk("R9 rising vec", int_vec, 7'h10);
        ack(); pulse_ei();
        ext_pin = 1'b0;
        repeat (3) tick();
        chk("R9 not before fourth edge", {6'd0, int_req}, 7'd0);
        tick();
        chk("R9 falling edge req", {6'd0, int_req}, 7'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule